// File: doc/BRIEF.md
# I2C SCL Rate Divider

This block derives the SCL clock of an I2C master from the system clock. Four counters are chained. The first counter counts a programmable half-period. The second divides by a power of two. The third divides by a programmable integer. The last is a fixed divide-by-ten stage, and it shapes the SCL level. The block produces the SCL level and a one-cycle tick at the end of every SCL period. Its rate depends on three settings: an 8-bit half-period count `hp`, a 4-bit multiplier `md` and a 3-bit exponent `nd`.

Software selects the divider values and writes them through two write ports. One port carries the half-period count. The other carries the multiplier and the exponent together. A write lands in a shadow copy first. The running counters switch to the shadow values only at the end of an SCL period, so a partly finished SCL phase is never cut short or stretched.

Top module: `scl_rate_div`

## Requirements
- R1: After reset `scl_level` and `period_tick` are 0, and the divider runs with hp = 24, md = 2 and nd = 0, which gives an SCL period of 1500 system cycles.
- R2: One SCL period lasts P = 20 × (hp + 1) × 2^nd × (md + 1) system cycles.
- R3: Within each period `scl_level` is low for the first P/2 cycles and high for the last P/2 cycles. It falls only in the cycle that follows a period tick.
- R4: `period_tick` is high for exactly one cycle per period. That cycle is the last cycle of the high phase.
- R5: When `cc_wr` is high, the multiplier md is taken from `cc_wdata[6:3]` and the exponent nd from `cc_wdata[2:0]`.
- R6: A write takes effect only at the next period boundary. The period in progress keeps its old length and its old phase split.
- R7: A half-period value below 5 that is written through `hp_wdata` is raised to 5.
- R8: The two registers are written independently. The register that is not written keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hp_wr | input | 1 | Write strobe for the half-period register |
| hp_wdata | input | 8 | Half-period count hp |
| cc_wr | input | 1 | Write strobe for the divider-control register |
| cc_wdata | input | 7 | md in bits 6:3, nd in bits 2:0 |
| scl_level | output | 1 | SCL level: low phase first, then high phase |
| period_tick | output | 1 | One-cycle pulse in the last cycle of each SCL period |

## Verification
A write reaches the shadow copy at the clock edge that samples it. It changes the timing only from the cycle after the next `period_tick`. The bench therefore issues each write in the first cycle after a tick. It then checks that the period still running has the old length, and that the following period has the new length and a high phase of exactly P/2 cycles. All timing is measured between ticks sampled on the falling clock edge. Because the count runs from one observed tick to the next, the interval equals P with no offset for register latency.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
    parameter int SD_HP_W = 8;   // half-period count width
    parameter int SD_MD_W = 4;   // multiplier width
    parameter int SD_ND_W = 3;   // power-of-two exponent width

    typedef struct packed {
        logic [SD_HP_W-1:0] hp;
        logic [SD_MD_W-1:0] md;
        logic [SD_ND_W-1:0] nd;
    } sd_cfg_t;
endpackage

// File: rtl/scl_div_cfg.sv
module scl_div_cfg
    import scl_div_pkg::*;
#(
    parameter int                 HP_MIN = 5,
    parameter logic [SD_HP_W-1:0] RST_HP = 8'h18,
    parameter logic [SD_MD_W-1:0] RST_MD = 4'd2,
    parameter logic [SD_ND_W-1:0] RST_ND = 3'd0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       hp_wr,
    input  logic [SD_HP_W-1:0]         hp_wdata,
    input  logic                       cc_wr,
    input  logic [SD_MD_W+SD_ND_W-1:0] cc_wdata,
    input  logic                       apply,
    output sd_cfg_t                    act_cfg
);
    localparam logic [SD_HP_W-1:0] HP_FLOOR = SD_HP_W'(HP_MIN);

    typedef struct packed {
        sd_cfg_t sh;    // written values, waiting for a period boundary
        sd_cfg_t act;   // values driving the counters
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hp_wr) begin
            st_d.sh.hp = (hp_wdata < HP_FLOOR) ? HP_FLOOR : hp_wdata;
        end
        if (cc_wr) begin
            st_d.sh.md = cc_wdata[SD_ND_W +: SD_MD_W];
            st_d.sh.nd = cc_wdata[SD_ND_W-1:0];
        end
        if (apply) begin
            st_d.act = st_q.sh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sh  <= '{hp: RST_HP, md: RST_MD, nd: RST_ND};
            st_q.act <= '{hp: RST_HP, md: RST_MD, nd: RST_ND};
        end else begin
            st_q <= st_d;
        end
    end

    assign act_cfg = st_q.act;
endmodule

// File: rtl/scl_div_stage.sv
module scl_div_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         wrap
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } stage_t;

    stage_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            st_d.cnt = (st_q.cnt >= limit) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
    assign wrap  = step && (st_q.cnt >= limit);
endmodule

// File: rtl/scl_rate_div.sv
module scl_rate_div
    import scl_div_pkg::*;
#(
    parameter int                 HP_MIN  = 5,
    parameter int                 FIX_DIV = 10,   // must be even
    parameter logic [SD_HP_W-1:0] RST_HP  = 8'h18,
    parameter logic [SD_MD_W-1:0] RST_MD  = 4'd2,
    parameter logic [SD_ND_W-1:0] RST_ND  = 3'd0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       hp_wr,
    input  logic [SD_HP_W-1:0]         hp_wdata,
    input  logic                       cc_wr,
    input  logic [SD_MD_W+SD_ND_W-1:0] cc_wdata,
    output logic                       scl_level,
    output logic                       period_tick
);
    localparam int NDS_W = 1 << SD_ND_W;         // wide enough for 2^(nd+1)-1
    localparam int FIX_W = $clog2(FIX_DIV);
    localparam logic [FIX_W-1:0] FIX_LIM  = FIX_W'(FIX_DIV - 1);
    localparam logic [FIX_W-1:0] FIX_HALF = FIX_W'(FIX_DIV / 2);

    sd_cfg_t            act_cfg;
    logic [SD_ND_W:0]   nd_p1;
    logic [NDS_W-1:0]   pow_lim;
    logic               hp_wrap, pow_wrap, md_wrap, fix_wrap;
    logic [SD_HP_W-1:0] hp_cnt;
    logic [NDS_W-1:0]   pow_cnt;
    logic [SD_MD_W-1:0] md_cnt;
    logic [FIX_W-1:0]   fix_cnt;

    scl_div_cfg #(
        .HP_MIN (HP_MIN),
        .RST_HP (RST_HP),
        .RST_MD (RST_MD),
        .RST_ND (RST_ND)
    ) cfg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .hp_wr    (hp_wr),
        .hp_wdata (hp_wdata),
        .cc_wr    (cc_wr),
        .cc_wdata (cc_wdata),
        .apply    (fix_wrap),
        .act_cfg  (act_cfg)
    );

    // Stage 2 counts 2 * 2^nd half-period pulses: limit is 2^(nd+1) - 1.
    // At nd = max the shift wraps to zero and the subtraction yields all ones.
    always_comb begin
        nd_p1   = {1'b0, act_cfg.nd} + 1'b1;
        pow_lim = (NDS_W'(1) << nd_p1) - NDS_W'(1);
    end

    scl_div_stage #(.W(SD_HP_W)) hp_stage_i (
        .clk (clk), .rst_n (rst_n), .step (1'b1),
        .limit (act_cfg.hp), .count (hp_cnt), .wrap (hp_wrap)
    );

    scl_div_stage #(.W(NDS_W)) pow_stage_i (
        .clk (clk), .rst_n (rst_n), .step (hp_wrap),
        .limit (pow_lim), .count (pow_cnt), .wrap (pow_wrap)
    );

    scl_div_stage #(.W(SD_MD_W)) md_stage_i (
        .clk (clk), .rst_n (rst_n), .step (pow_wrap),
        .limit (act_cfg.md), .count (md_cnt), .wrap (md_wrap)
    );

    scl_div_stage #(.W(FIX_W)) fix_stage_i (
        .clk (clk), .rst_n (rst_n), .step (md_wrap),
        .limit (FIX_LIM), .count (fix_cnt), .wrap (fix_wrap)
    );

    // Low for the first half of the fixed stage, high for the second half.
    assign scl_level   = (fix_cnt >= FIX_HALF);
    assign period_tick = fix_wrap;
endmodule

// File: rtl/scl_rate_div_chk.sv
module scl_rate_div_chk #(
    parameter int HP_W   = 8,
    parameter int HP_MIN = 5,
    parameter int CFG_W  = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_level,
    input logic             period_tick,
    input logic [CFG_W-1:0] act_cfg
);
    logic [HP_W-1:0] act_hp;
    assign act_hp = act_cfg[CFG_W-1 -: HP_W];

    a_r4_tick_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        period_tick |=> !period_tick);

    a_r3_high_at_tick: assert property (@(posedge clk) disable iff (!rst_n)
        period_tick |-> scl_level);

    a_r3_low_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        period_tick |=> !scl_level);

    a_r3_fall_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_level) |-> $past(period_tick));

    a_r6_cfg_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_cfg) |-> $past(period_tick));

    a_r7_hp_floor: assert property (@(posedge clk) disable iff (!rst_n)
        act_hp >= HP_W'(HP_MIN));
endmodule

bind scl_rate_div scl_rate_div_chk #(
    .HP_W   (scl_div_pkg::SD_HP_W),
    .HP_MIN (HP_MIN),
    .CFG_W  ($bits(scl_div_pkg::sd_cfg_t))
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_level   (scl_level),
    .period_tick (period_tick),
    .act_cfg     (act_cfg)
);

// File: tb/scl_rate_div_tb.sv
`timescale 1ns/1ps
module scl_rate_div_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       hp_wr = 1'b0;
    logic [7:0] hp_wdata = '0;
    logic       cc_wr = 1'b0;
    logic [6:0] cc_wdata = '0;
    logic       scl_level, period_tick;

    int vectors = 0;
    int fails   = 0;

    // bench model of the written registers
    int m_hp = 24, m_md = 2, m_nd = 0;

    always #4 clk = ~clk;   // 125 MHz

    scl_rate_div dut_i (
        .clk (clk), .rst_n (rst_n),
        .hp_wr (hp_wr), .hp_wdata (hp_wdata),
        .cc_wr (cc_wr), .cc_wdata (cc_wdata),
        .scl_level (scl_level), .period_tick (period_tick)
    );

    function automatic int exp_period(input int hp, input int md, input int nd);
        int t;
        t = (hp < 5) ? 5 : hp;   // R7 floor
        return 20 * (t + 1) * (1 << nd) * (md + 1);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (!period_tick);
    endtask

    // Called right after an observed tick. Counts one full period, and can
    // issue writes in its first cycle. Returns length and high-phase cycles.
    task automatic run_period(input bit do_hp, input int hp, input bit do_cc,
                              input int md, input int nd,
                              output int len, output int hi);
        len = 0; hi = 0;
        hp_wr    = do_hp;
        hp_wdata = 8'(hp);
        cc_wr    = do_cc;
        cc_wdata = {4'(md), 3'(nd)};   // R5: md in 6:3, nd in 2:0
        do begin
            @(negedge clk);
            hp_wr = 1'b0;
            cc_wr = 1'b0;
            len++;
            if (scl_level) hi++;
        end while (!period_tick);
    endtask

    task automatic apply_cfg(input bit do_hp, input int hp, input bit do_cc,
                             input int md, input int nd);
        int old_p, new_p, len, hi;
        old_p = exp_period(m_hp, m_md, m_nd);
        run_period(do_hp, hp, do_cc, md, nd, len, hi);
        chk("R6 old period kept", len, old_p);
        chk("R6 old high phase kept", hi, old_p / 2);
        if (do_hp) m_hp = hp;          // R8: only the written register moves
        if (do_cc) begin m_md = md; m_nd = nd; end
        new_p = exp_period(m_hp, m_md, m_nd);
        run_period(1'b0, 0, 1'b0, 0, 0, len, hi);
        chk("R2 period", len, new_p);
        chk("R3 high phase half", hi, new_p / 2);
    endtask

    initial begin
        int len, hi;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk("R1 scl low in reset", int'(scl_level), 0);
        chk("R1 tick low in reset", int'(period_tick), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 scl low after reset", int'(scl_level), 0);
        wait_tick();
        chk("R4 scl high at tick", int'(scl_level), 1);
        @(negedge clk);
        chk("R3 scl low after tick", int'(scl_level), 0);
        chk("R4 tick single cycle", int'(period_tick), 0);
        wait_tick();
        run_period(1'b0, 0, 1'b0, 0, 0, len, hi);
        chk("R1 default period", len, 1500);
        chk("R1 default high phase", hi, 750);

        // directed corners
        apply_cfg(1'b1, 5, 1'b1, 0, 0);     // smallest legal setting
        apply_cfg(1'b1, 3, 1'b0, 0, 0);     // R7 clamp
        apply_cfg(1'b1, 0, 1'b0, 0, 0);     // R7 clamp of zero
        apply_cfg(1'b0, 0, 1'b1, 15, 0);    // R5 md maximum, R8 hp kept
        apply_cfg(1'b0, 0, 1'b1, 0, 7);     // R5 nd maximum
        apply_cfg(1'b1, 255, 1'b1, 0, 0);   // hp maximum
        apply_cfg(1'b1, 4, 1'b1, 1, 1);     // R7 clamp with other stages

        // random settings kept short enough for the run budget
        for (int i = 0; i < 10; i++) begin
            apply_cfg(1'($urandom_range(0, 1)) | (i == 0), $urandom_range(0, 12),
                      1'($urandom_range(0, 1)), $urandom_range(0, 2),
                      $urandom_range(0, 1));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule